// File: doc/BRIEF.md
# Multi-Mode Raster Sync Timing Generator

This block drives the timing side of an analogue video output. It keeps two counters in the pixel clock: one gives the position inside the line and one gives the line inside the frame. From them it derives horizontal sync, vertical sync, a data-enable flag, and the pixel and line coordinates of the visible picture. It also gives one-cycle markers for the first and last clock of each frame. A downstream pixel source uses `de`, `x` and `y` to fetch and present colour data. Producing the pixel clock and converting colour are done elsewhere.

Five display timings are built in, one per mode number. Each has its own porch lengths, sync widths and sync polarities. Every line and every frame begins with the sync pulse, then the back porch, then the visible region, and ends with the front porch. The mode select is sampled only when a frame wraps, or when the block starts up from idle, so no frame ever mixes two timings. All timing values are parameters, which allows a bench to use a scaled-down set.

Top module: `vga_sync_gen`

## Requirements
- R1: One line lasts act+fp+sw+bp pixel clocks of the horizontal set, and one frame lasts act+fp+sw+bp lines of the vertical set, both from the mode in force for that frame.
- R2: Within a line, horizontal sync is asserted for the first sw clocks (positions 0..sw-1). The visible region covers positions sw+bp up to sw+bp+act-1, and the front porch fills the rest.
- R3: Within a frame, vertical sync is asserted for the first sw lines, counted in whole lines. Visible lines are sw+bp up to sw+bp+act-1, and the front porch lines close the frame.
- R4: Sync polarity is set per mode. Horizontal sync is active high in modes 1 and 4 and active low in modes 0, 2 and 3. Vertical sync is active high in modes 1, 2 and 3 and active low in modes 0 and 4. When a sync is inactive it sits at the opposite level.
- R5: `mode_sel` encodes 0 = 640x480@60, 1 = 800x600@60, 2 = 800x600@100, 3 = 640x400@70, 4 = 640x350@70 (default parameters). Values 5 to 7 select mode 0.
- R6: `de` is high exactly in the visible region. While `de` is high, `x` = line position minus (sw+bp) and `y` = line number minus (sw+bp) of the vertical set. While `de` is low, both are 0.
- R7: `sof` is a one-cycle pulse on the first clock of each frame (position 0 of line 0). `vs_edge` pulses in that same cycle, when vertical sync becomes asserted.
- R8: `eof` is a one-cycle pulse on the last clock of the last front-porch line. If `en` stays high, `sof` follows in the next cycle.
- R9: A change of `mode_sel` during a frame has no effect until that frame wraps. The next frame uses the new mode.
- R10: While `en` is low, the block is idle: both syncs are at their inactive level, and `de`, `sof`, `eof` and `vs_edge` are 0. The clock edge that first samples `en` high also loads the mode and starts a frame, so `sof` is visible right after that edge.
- R11: After reset, the block is idle in mode 0, with both syncs at the inactive level of mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds the block idle |
| mode_sel | input | MW (3) | Display mode number |
| hsync | output | 1 | Horizontal sync at the mode's polarity |
| vsync | output | 1 | Vertical sync at the mode's polarity |
| de | output | 1 | Visible-region flag |
| x | output | CW (12) | Pixel column inside the visible region |
| y | output | CW (12) | Line number inside the visible region |
| sof | output | 1 | First clock of a frame |
| eof | output | 1 | Last clock of a frame |
| vs_edge | output | 1 | Vertical sync becomes asserted |

## Verification
A wrong horizontal count shows up within one line. It appears as a misplaced sync edge, a shifted `de` window or a broken `x` ramp. A wrong vertical count or a wrong latched mode shows up at the latest at the next frame wrap, as a wrong `sof` to `sof` distance or a wrong sync level. The bench sweeps every mode and the out-of-range select values on a shrunken parameter set. It compares every output on every clock against a position model worked out from the requirements, and it measures the frame period between start markers. It also switches the mode in mid-frame and drops the enable in mid-frame, checking that the frame in progress is left intact and that the block restarts cleanly.

// File: rtl/vga_sync_gen.sv
module vga_sync_gen #(
  parameter int CW = 12,
  parameter int NM = 5,
  localparam int MW = $clog2(NM),
  parameter logic [NM*CW-1:0] H_ACT = {12'd640, 12'd640, 12'd800, 12'd800, 12'd640},
  parameter logic [NM*CW-1:0] H_FP  = {12'd16,  12'd16,  12'd48,  12'd40,  12'd16},
  parameter logic [NM*CW-1:0] H_SW  = {12'd96,  12'd96,  12'd88,  12'd128, 12'd96},
  parameter logic [NM*CW-1:0] H_BP  = {12'd48,  12'd48,  12'd136, 12'd88,  12'd48},
  parameter logic [NM*CW-1:0] V_ACT = {12'd350, 12'd400, 12'd600, 12'd600, 12'd480},
  parameter logic [NM*CW-1:0] V_FP  = {12'd37,  12'd12,  12'd1,   12'd1,   12'd10},
  parameter logic [NM*CW-1:0] V_SW  = {12'd2,   12'd2,   12'd3,   12'd4,   12'd2},
  parameter logic [NM*CW-1:0] V_BP  = {12'd60,  12'd35,  12'd32,  12'd23,  12'd33},
  parameter logic [NM-1:0]    H_POL = 5'b10010,
  parameter logic [NM-1:0]    V_POL = 5'b01110
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [MW-1:0] mode_sel,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] x,
  output logic [CW-1:0] y,
  output logic          sof,
  output logic          eof,
  output logic          vs_edge
);

  logic          run;
  logic [MW-1:0] cur, sel_ok;
  logic [CW-1:0] h, v;
  logic [CW-1:0] hact, hfp, hsw, hbp, vact, vfp, vsw, vbp;
  logic [CW-1:0] htot, vtot, hstart, vstart;
  logic          h_last, v_last, hs_on, vs_on, h_in, v_in;

  assign sel_ok = (mode_sel < MW'(NM)) ? mode_sel : '0;

  assign hact = H_ACT[cur*CW +: CW];
  assign hfp  = H_FP [cur*CW +: CW];
  assign hsw  = H_SW [cur*CW +: CW];
  assign hbp  = H_BP [cur*CW +: CW];
  assign vact = V_ACT[cur*CW +: CW];
  assign vfp  = V_FP [cur*CW +: CW];
  assign vsw  = V_SW [cur*CW +: CW];
  assign vbp  = V_BP [cur*CW +: CW];

  assign htot   = hact + hfp + hsw + hbp;
  assign vtot   = vact + vfp + vsw + vbp;
  assign hstart = hsw + hbp;
  assign vstart = vsw + vbp;
  assign h_last = (h == htot - CW'(1));
  assign v_last = (v == vtot - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      h   <= '0;
      v   <= '0;
      cur <= '0;
    end else if (!en || !run) begin
      run <= en;
      h   <= '0;
      v   <= '0;
      cur <= sel_ok;
    end else if (h_last) begin
      h <= '0;
      if (v_last) begin
        v   <= '0;
        cur <= sel_ok;
      end else begin
        v <= v + CW'(1);
      end
    end else begin
      h <= h + CW'(1);
    end
  end

  assign hs_on = run && (h < hsw);
  assign vs_on = run && (v < vsw);
  assign h_in  = (h >= hstart) && (h < hstart + hact);
  assign v_in  = (v >= vstart) && (v < vstart + vact);

  assign hsync   = hs_on ^ ~H_POL[cur];
  assign vsync   = vs_on ^ ~V_POL[cur];
  assign de      = run && h_in && v_in;
  assign x       = de ? h - hstart : '0;
  assign y       = de ? v - vstart : '0;
  assign sof     = run && (h == '0) && (v == '0);
  assign eof     = run && h_last && v_last;
  assign vs_edge = sof && vs_on;

endmodule

// File: rtl/vga_sync_gen_chk.sv
module vga_sync_gen_chk #(
  parameter int CW = 12,
  parameter int NM = 5,
  localparam int MW = $clog2(NM)
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [MW-1:0] mode_sel,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic [CW-1:0] x,
  input logic [CW-1:0] y,
  input logic          sof,
  input logic          eof,
  input logic          vs_edge
);

  // R8
  eof_then_sof_chk: assert property (@(posedge clk) disable iff (rst)
    eof && en |=> sof);

  // R6
  x_step_chk: assert property (@(posedge clk) disable iff (rst)
    de && $past(de) |-> (x == $past(x) + CW'(1)) && (y == $past(y)));

  // R6
  x_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(de) |-> x == '0);

  // R6
  xy_blank_chk: assert property (@(posedge clk) disable iff (rst)
    !de |-> (x == '0) && (y == '0));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !de && !sof && !eof && !vs_edge);

  // R7
  sof_edge_chk: assert property (@(posedge clk) disable iff (rst)
    sof |-> vs_edge && !eof && !de);

endmodule

bind vga_sync_gen vga_sync_gen_chk #(.CW(CW), .NM(NM)) u_chk (.*);

// File: tb/test_vga_sync_gen.sv
module test_vga_sync_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;

  int ha [5] = '{8, 10, 6, 8, 8};
  int hf [5] = '{2, 1, 3, 2, 2};
  int hs [5] = '{3, 4, 2, 3, 3};
  int hb [5] = '{2, 3, 4, 2, 2};
  int va [5] = '{4, 5, 3, 3, 2};
  int vf [5] = '{1, 2, 1, 2, 3};
  int vs [5] = '{2, 1, 3, 2, 2};
  int vb [5] = '{2, 3, 2, 1, 4};
  bit hp [5] = '{0, 1, 0, 0, 1};
  bit vp [5] = '{0, 1, 1, 1, 0};

  logic clk = 0, rst = 1, en = 0;
  logic [2:0] mode_sel = 0;
  logic hsync, vsync, de, sof, eof, vs_edge;
  logic [CW-1:0] x, y;

  int checks = 0, fails = 0, cyc = 0;
  int mh = 0, mv = 0, mm = 0;
  bit mrun = 0, done = 0;
  int last_sof = -1, exp_period = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vga_sync_gen #(
    .CW(CW), .NM(5),
    .H_ACT({12'd8, 12'd8, 12'd6, 12'd10, 12'd8}),
    .H_FP ({12'd2, 12'd2, 12'd3, 12'd1,  12'd2}),
    .H_SW ({12'd3, 12'd3, 12'd2, 12'd4,  12'd3}),
    .H_BP ({12'd2, 12'd2, 12'd4, 12'd3,  12'd2}),
    .V_ACT({12'd2, 12'd3, 12'd3, 12'd5,  12'd4}),
    .V_FP ({12'd3, 12'd2, 12'd1, 12'd2,  12'd1}),
    .V_SW ({12'd2, 12'd2, 12'd3, 12'd1,  12'd2}),
    .V_BP ({12'd4, 12'd1, 12'd2, 12'd3,  12'd2})
  ) i_vga_sync_gen (.*);

  function automatic int map_sel(int s);
    return (s < 5) ? s : 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic compare();
    int ht = ha[mm] + hf[mm] + hs[mm] + hb[mm];
    int vt = va[mm] + vf[mm] + vs[mm] + vb[mm];
    bit hon = mrun && (mh < hs[mm]);
    bit von = mrun && (mv < vs[mm]);
    bit ein = mrun && mh >= hs[mm] + hb[mm] && mh < hs[mm] + hb[mm] + ha[mm]
              && mv >= vs[mm] + vb[mm] && mv < vs[mm] + vb[mm] + va[mm];
    bit esof = mrun && mh == 0 && mv == 0;
    bit eeof = mrun && mh == ht - 1 && mv == vt - 1;
    int ex = ein ? mh - hs[mm] - hb[mm] : 0;
    int ey = ein ? mv - vs[mm] - vb[mm] : 0;
    // R2, R4: horizontal sync position and level
    chk(hsync == (hp[mm] ? hon : !hon), "R2 R4 hsync", hsync, hp[mm] ? hon : !hon);
    // R3, R4: vertical sync position and level
    chk(vsync == (vp[mm] ? von : !von), "R3 R4 vsync", vsync, vp[mm] ? von : !von);
    // R6
    chk(de == ein && int'(x) == ex && int'(y) == ey, "R6 de/x/y",
        {de, x, y}, {ein, ex[11:0], ey[11:0]});
    // R7, R8
    chk(sof == esof && vs_edge == esof && eof == eeof, "R7 R8 markers",
        {sof, vs_edge, eof}, {esof, esof, eeof});
    // R1: frame period between start markers
    if (!mrun) last_sof = -1;
    if (esof) begin
      if (last_sof >= 0) chk(cyc - last_sof == exp_period, "R1 frame period", cyc - last_sof, exp_period);
      last_sof = cyc;
      exp_period = ht * vt;
    end
  endtask

  task automatic tick();
    int ht, vt;
    @(posedge clk);
    cyc++;
    ht = ha[mm] + hf[mm] + hs[mm] + hb[mm];
    vt = va[mm] + vf[mm] + vs[mm] + vb[mm];
    if (!en || !mrun) begin
      mrun = en; mh = 0; mv = 0; mm = map_sel(mode_sel);
    end else if (mh == ht - 1) begin
      mh = 0;
      if (mv == vt - 1) begin mv = 0; mm = map_sel(mode_sel); end
      else mv++;
    end else mh++;
    @(negedge clk);
    compare();
  endtask

  task automatic run_frames(int n);
    int seen = 0;
    for (int k = 0; k < 5000 && seen <= n; k++) begin
      tick();
      if (sof) seen++;
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R11: idle in mode 0 during reset, mode 0 syncs are active low
    chk(hsync == 1 && vsync == 1, "R11 reset syncs", {hsync, vsync}, 2'b11);
    chk(!de && !sof && !eof && !vs_edge && x == 0 && y == 0, "R11 reset idle",
        {de, sof, eof, vs_edge}, 0);
    rst = 0;
    tick();

    // R1 to R8 and R5 fallback: sweep every mode and the select value 6
    for (int m = 0; m < 7; m++) begin
      if (m == 5) continue;
      en = 0; mode_sel = 3'(m);
      tick(); tick();
      // R10: idle outputs while disabled
      chk(!de && !sof && hsync == !hp[map_sel(m)], "R10 idle", {de, sof, hsync}, {2'b00, !hp[map_sel(m)]});
      en = 1;
      tick();
      // R10: start marker right after the enabling edge
      chk(sof == 1, "R10 start", sof, 1);
      run_frames(2);
    end

    // R9: mode change mid-frame waits for the wrap
    en = 0; mode_sel = 1; tick();
    en = 1; tick();
    for (int k = 0; k < 30; k++) tick();
    mode_sel = 2;
    run_frames(2);
    chk(mm == 2, "R9 mode latched", mm, 2);

    // R10: disable mid-frame, then restart in mode 4
    for (int k = 0; k < 20; k++) tick();
    en = 0; mode_sel = 4;
    for (int k = 0; k < 5; k++) tick();
    en = 1;
    tick();
    chk(sof == 1 && vsync == 0, "R10 restart", {sof, vsync}, 2'b10);
    run_frames(1);
    finish_up();
  end
endmodule